// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command and status logic of a parallel NOR-style flash device with a small internal array. Bus writes are taken when chip enable and write enable are both low at a rising clock edge. Each accepted byte is decoded as a command or as the second cycle of a two-step program or erase sequence. A write state machine holds the device busy for a programmable number of cycles and then applies the change to the array. An eight-bit status register reports whether the machine is ready, whether the last program or erase failed, and whether the programming supply was out of range.

A reset/power-down pin aborts any operation in progress, clears status and puts the device into deep power-down. While that pin is low, all control inputs are ignored and the data outputs stay off. When the pin rises, a wake-up count must expire before the device accepts commands again. A core-supply-valid input returns the command interface to array reads whenever the supply is low. After an operation finishes, the device stays in status mode until a Read Array command is written.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write is accepted only at a clock edge where `ce_n` and `we_n` are both 0, `rp_n` is 1, `vcc_ok` is 1, the wake-up count has expired and the state machine is idle. Any other write has no effect on mode, status or array.
- R2: Command byte 0xFF selects array mode and 0x70 selects status mode. In status mode, and in either setup mode, reads return the status byte at any address. Status bit 7 is ready (1 = idle), bit 5 is erase fail, bit 4 is program fail, bit 3 is supply fault, and the other bits read 0.
- R3: Writing 0x40 and then an address/data write programs that word to old AND data. The device then enters status mode.
- R4: Writing 0x20 and then 0xD0 erases a block. The block is selected by the address bits above the low `BLK_AW` bits of the confirm write, and every word in it is set to all ones.
- R5: An erase setup followed by any byte other than 0xD0 sets status bits 5 and 4 and leaves the array unchanged.
- R6: The ready bit reads 0 for exactly `BUSY_CYC` cycles after the second write of an operation, and the array change becomes visible when the ready bit returns to 1.
- R7: If `vpp_ok` is 0 when an operation starts, or at any cycle while it is busy, status bit 3 is set together with bit 4 (program) or bit 5 (erase), and the array is not changed.
- R8: Command 0x50 clears status bits 5, 4 and 3 and leaves the mode unchanged.
- R9: After an operation completes, reads keep returning status until 0xFF is written.
- R10: `rp_n` low aborts any operation with the array word left as it was, clears status bits 5, 4 and 3, selects array mode, and forces `dq_oe` to 0 from the next edge. Writes made while it is low are ignored.
- R11: After `rp_n` is first sampled high, the first `WAKE_CYC` edges ignore writes and do not enable the outputs.
- R12: `rst` clears status, selects array mode and fills the array with all ones. `vcc_ok` low selects array mode and blocks writes.
- R13: `dq_oe` goes to 1 one cycle after an edge where `ce_n` and `oe_n` are 0, `we_n` is 1 and the device is awake. `dq_out` is registered on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-off reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rp_n | input | 1 | Reset/deep power-down, active low |
| vpp_ok | input | 1 | Programming supply within range |
| vcc_ok | input | 1 | Core supply above lockout |
| addr | input | AW | Word address |
| dq_in | input | DW | Data bus input side |
| dq_out | output | DW | Data bus output side (registered) |
| dq_oe | output | 1 | Data bus drive enable (registered) |

## Verification
The two functions that can land on the same edge are completion of the write state machine and a power-down abort from `rp_n`. The bench starts a program and drops `rp_n` so that the fall lands on exactly the edge where the busy count would expire. It then waits out the wake-up count and reads the word back. The word must hold its old value and the status must be clean. A matching program run without the abort fixes the exact completion edge by reading status on the last busy cycle and on the first idle cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;

  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_PSETUP, M_ESETUP} mode_t;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_t;
endpackage

// File: rtl/flash_cui.sv
module flash_cui
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep,
  input  logic       wr,
  input  logic [7:0] wbyte,
  output mode_t      mode,
  output logic       start_prog,
  output logic       start_erase,
  output logic       seq_err,
  output logic       clr_stat
);
  mode_t mode_nx;

  always_comb begin
    mode_nx     = mode;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    seq_err     = 1'b0;
    clr_stat    = 1'b0;
    if (wr) begin
      case (mode)
        M_PSETUP: begin
          start_prog = 1'b1;
          mode_nx    = M_STATUS;
        end
        M_ESETUP: begin
          if (wbyte == CMD_CONFIRM) start_erase = 1'b1;
          else                      seq_err     = 1'b1;
          mode_nx = M_STATUS;
        end
        default: begin
          case (wbyte)
            CMD_RD_ARRAY: mode_nx  = M_ARRAY;
            CMD_RD_STAT:  mode_nx  = M_STATUS;
            CMD_CLR_STAT: clr_stat = 1'b1;
            CMD_PROG:     mode_nx  = M_PSETUP;
            CMD_ERASE:    mode_nx  = M_ESETUP;
            default:      ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sleep) mode <= M_ARRAY;
    else              mode <= mode_nx;
  end
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int BUSY_CYC = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          vpp_ok,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic          seq_err,
  input  logic          clr_stat,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic [7:0]    stat,
  output logic          commit_prog,
  output logic          commit_erase,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt;
  op_t           op;
  logic          vlost, vfail, pfail, efail;
  logic          last, good_end;

  assign last     = busy && (cnt == CW'(1));
  assign good_end = last && !vlost && vpp_ok && !abort;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy  <= 1'b0;
      cnt   <= '0;
      op    <= OP_NONE;
      vlost <= 1'b0;
      vfail <= 1'b0;
      pfail <= 1'b0;
      efail <= 1'b0;
    end else if (busy) begin
      if (!vpp_ok) vlost <= 1'b1;
      cnt <= cnt - 1'b1;
      if (last) begin
        busy <= 1'b0;
        op   <= OP_NONE;
        if (vlost || !vpp_ok) begin
          vfail <= 1'b1;
          if (op == OP_PROG) pfail <= 1'b1;
          else               efail <= 1'b1;
        end
      end
    end else if (start_prog || start_erase) begin
      if (!vpp_ok) begin
        vfail <= 1'b1;
        pfail <= pfail | start_prog;
        efail <= efail | start_erase;
      end else begin
        busy    <= 1'b1;
        cnt     <= CW'(BUSY_CYC);
        op      <= start_prog ? OP_PROG : OP_ERASE;
        vlost   <= 1'b0;
        op_addr <= addr;
        op_data <= wdata;
      end
    end else if (seq_err) begin
      pfail <= 1'b1;
      efail <= 1'b1;
    end else if (clr_stat) begin
      vfail <= 1'b0;
      pfail <= 1'b0;
      efail <= 1'b0;
    end
  end

  assign commit_prog  = good_end && (op == OP_PROG);
  assign commit_erase = good_end && (op == OP_ERASE);
  assign stat = {~busy, 1'b0, efail, pfail, vfail, 3'b000};
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int BLK_AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_en,
  input  logic          erase_en,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst)
        mem[i] <= '1;
      else if (erase_en && ((AW'(i) >> BLK_AW) == (waddr >> BLK_AW)))
        mem[i] <= '1;
      else if (prog_en && (AW'(i) == waddr))
        mem[i] <= mem[i] & wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int BLK_AW   = 2,
  parameter int BUSY_CYC = 6,
  parameter int WAKE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          rp_n,
  input  logic          vpp_ok,
  input  logic          vcc_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  localparam int WW = $clog2(WAKE_CYC + 1);

  logic [WW-1:0] wake_cnt;
  logic          awake, cmd_wr, sleep;
  mode_t         mode;
  logic          start_prog, start_erase, seq_err, clr_stat;
  logic          busy, commit_prog, commit_erase;
  logic [7:0]    stat;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data, arr_rd;

  always_ff @(posedge clk) begin
    if (rst)                  wake_cnt <= '0;
    else if (!rp_n)           wake_cnt <= WW'(WAKE_CYC);
    else if (wake_cnt != '0)  wake_cnt <= wake_cnt - 1'b1;
  end

  assign awake  = rp_n && (wake_cnt == '0);
  assign sleep  = !rp_n || !vcc_ok;
  assign cmd_wr = awake && vcc_ok && !busy && !ce_n && !we_n;

  flash_cui u_cui (
    .clk(clk), .rst(rst), .sleep(sleep), .wr(cmd_wr), .wbyte(dq_in[7:0]),
    .mode(mode), .start_prog(start_prog), .start_erase(start_erase),
    .seq_err(seq_err), .clr_stat(clr_stat)
  );

  flash_wsm #(.AW(AW), .DW(DW), .BUSY_CYC(BUSY_CYC)) u_wsm (
    .clk(clk), .rst(rst), .abort(!rp_n), .vpp_ok(vpp_ok),
    .start_prog(start_prog), .start_erase(start_erase),
    .seq_err(seq_err), .clr_stat(clr_stat), .addr(addr), .wdata(dq_in),
    .busy(busy), .stat(stat), .commit_prog(commit_prog),
    .commit_erase(commit_erase), .op_addr(op_addr), .op_data(op_data)
  );

  flash_array #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW)) u_arr (
    .clk(clk), .rst(rst), .prog_en(commit_prog), .erase_en(commit_erase),
    .waddr(op_addr), .wdata(op_data), .raddr(addr), .rdata(arr_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe  <= awake && !ce_n && !oe_n && we_n;
      dq_out <= (mode == M_ARRAY) ? arr_rd : DW'(stat);
    end
  end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       rp_n,
  input logic       vpp_ok,
  input logic       vcc_ok,
  input logic       dq_oe,
  input logic       busy,
  input logic [7:0] stat,
  input mode_t      mode
);
  // R10
  rp_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !rp_n |=> !dq_oe);

  // R10
  rp_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !rp_n |=> (stat[5:3] == 3'b000 && !busy));

  // R13
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(!ce_n && !oe_n && we_n && rp_n));

  // R7
  vpp_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[3]) |-> (stat[4] || stat[5]));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!ce_n && !we_n && rp_n && vpp_ok && vcc_ok));

  // R12
  vcc_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !vcc_ok |=> (mode == M_ARRAY));

  // R2
  stat_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stat[6] == 1'b0 && stat[2:0] == 3'b000);
endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .rp_n(rp_n), .vpp_ok(vpp_ok), .vcc_ok(vcc_ok), .dq_oe(dq_oe),
  .busy(busy), .stat(stat), .mode(mode)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int AW = 4, DW = 8, BLK_AW = 2, BUSY = 6, WAKE = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, rp_n = 1'b1;
  logic vpp_ok = 1'b1, vcc_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0, dq_out;
  logic dq_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];
  logic [7:0] rv;
  logic       ro;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW), .BUSY_CYC(BUSY), .WAKE_CYC(WAKE))
    u_flash_cmd_ctrl (.clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .rp_n(rp_n), .vpp_ok(vpp_ok), .vcc_ok(vcc_ok), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // each task starts at a falling edge and consumes exactly one rising edge
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; addr = a; dq_in = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    rv = dq_out; ro = dq_oe;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rd(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    rd(a);
    check(req, {ro, rv}, {1'b1, exp});
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) ^ 8'h5A);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R6: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R12 oe after reset", {31'b0, dq_oe}, 0);
    for (int a = 0; a < DEPTH; a++) expect_rd("R12 erased array", AW'(a), 8'hFF);

    // status read at several addresses
    wr(0, 8'h70);
    for (int a = 0; a < DEPTH; a += 5) expect_rd("R2 status any address", AW'(a), 8'h80);
    wr(0, 8'hFF);
    expect_rd("R2 back to array", 1, 8'hFF);

    // R3 R6 R9 program sweep with exact busy window
    for (int a = 0; a < DEPTH; a++) begin
      wr(AW'(a), 8'h40);
      expect_rd("R2 setup reads status", AW'(a), 8'h80);
      wr(AW'(a), pat(a));
      model[a] = model[a] & pat(a);
      expect_rd("R6 busy first cycle", AW'(a), 8'h00);
      idle(BUSY - 2);
      expect_rd("R6 busy last cycle", AW'(a), 8'h00);
      expect_rd("R6 ready after window", AW'(a), 8'h80);
      expect_rd("R9 stays in status", AW'(a + 1), 8'h80);
      wr(0, 8'hFF);
      expect_rd("R3 programmed word", AW'(a), model[a]);
    end
    wr(3, 8'h40); wr(3, 8'h0F); model[3] = model[3] & 8'h0F;
    idle(BUSY + 1); wr(0, 8'hFF);
    expect_rd("R3 program ANDs", 3, model[3]);

    // R4 erase block 1
    wr(5, 8'h20); wr(5, 8'hD0);
    idle(BUSY + 1);
    expect_rd("R4 erase done status", 0, 8'h80);
    wr(0, 8'hFF);
    for (int a = 4; a < 8; a++) model[a] = 8'hFF;
    for (int a = 0; a < DEPTH; a++) expect_rd("R4 erase block", AW'(a), model[a]);

    // R5 bad confirm, R8 clear
    wr(9, 8'h20); wr(9, 8'h33);
    expect_rd("R5 sequence error", 0, 8'hB0);
    wr(0, 8'h50);
    expect_rd("R8 clear keeps status mode", 0, 8'h80);
    wr(0, 8'hFF);
    for (int a = 8; a < 12; a++) expect_rd("R5 array untouched", AW'(a), model[a]);

    // R1 write with chip disabled ignored
    ce_n = 1'b1; we_n = 1'b0; dq_in = 8'h70; idle(1); we_n = 1'b1;
    expect_rd("R1 ce high ignored", 2, model[2]);

    // R1 write while busy ignored
    wr(8, 8'h40); wr(8, 8'h00); model[8] = 8'h00;
    wr(0, 8'hFF);
    idle(BUSY);
    expect_rd("R1 busy write ignored", 8, 8'h80);

    // R7 supply fault at start
    vpp_ok = 1'b0;
    wr(2, 8'h40); wr(2, 8'h00);
    expect_rd("R7 program fault", 2, 8'h98);
    vpp_ok = 1'b1;
    wr(0, 8'h50);
    wr(10, 8'h20); wr(10, 8'hD0);
    idle(2); vpp_ok = 1'b0; idle(1); vpp_ok = 1'b1;
    idle(BUSY);
    expect_rd("R7 erase fault during busy", 0, 8'hA8);
    wr(0, 8'hFF);
    expect_rd("R7 program not applied", 2, model[2]);
    for (int a = 8; a < 12; a++) expect_rd("R7 erase not applied", AW'(a), model[a]);

    // R10 abort, R11 wake gating of writes
    wr(0, 8'h20); wr(0, 8'h11);
    wr(12, 8'h40); wr(12, 8'h00);
    idle(1);
    rp_n = 1'b0;
    rd(12);
    check("R10 outputs off in power-down", {31'b0, ro}, 0);
    wr(0, 8'h70);
    idle(2);
    rp_n = 1'b1;
    idle(WAKE - 1);
    wr(0, 8'h70);
    expect_rd("R11 write during wake ignored", 12, model[12]);
    expect_rd("R10 abort left word", 12, model[12]);
    wr(0, 8'h70);
    expect_rd("R10 status cleared", 0, 8'h80);
    wr(0, 8'hFF);

    // R11 outputs stay off during wake
    rp_n = 1'b0; idle(1); rp_n = 1'b1;
    idle(WAKE - 1);
    rd(1);
    check("R11 oe off during wake", {31'b0, ro}, 0);
    expect_rd("R11 oe on after wake", 1, model[1]);

    // collision: power-down on the completion edge
    wr(13, 8'h40); wr(13, 8'h00);
    idle(BUSY - 1);
    rp_n = 1'b0; idle(1); rp_n = 1'b1;
    idle(WAKE);
    expect_rd("R10 abort on completion edge", 13, model[13]);
    wr(0, 8'h70);
    expect_rd("R10 clean status after collision", 0, 8'h80);

    // R12 core supply low
    vcc_ok = 1'b0;
    wr(0, 8'h40);
    vcc_ok = 1'b1;
    expect_rd("R12 lockout returns array mode", 13, model[13]);
    wr(13, 8'h00);
    idle(BUSY);
    expect_rd("R12 setup blocked in lockout", 13, model[13]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule